// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller with Interrupt Pin Driver

This block watches eight general-purpose input pins and turns selected transitions on them into interrupts. Each pin has three control bits: a sticky pending flag, an enable, and an edge-select bit that chooses rising or falling transitions. All three are changed through a simple register-write port. The flags clear only when software writes a 1 to them. The current values are brought out so that the surrounding register file can return them on reads.

The enabled pending flags are ORed with an external summary of the chip's other interrupt sources. The result drives one interrupt pin, which works in one of two modes:
- **Level mode:** the pin is an active-low, open-drain pull-down.
- **Edge mode:** the pin is a push-pull output that gives one pulse of programmable polarity and width each time the combined condition becomes active.

A global enable must be set before the pin signals anything. A multiplexed general-purpose output can be switched so that it carries only the GPIO interrupt. In that case the GPIO flags are removed from the main interrupt pin.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, all pending flags, enables and edge-select bits read 0. The interrupt pin is released (`int_oe_o`=0, `int_o`=0). `gpx_o` follows `gpx_src_i`.
- R2: Each input passes through a two-flop synchronizer. A pending flag sets on a rising transition of its input when its edge-select bit is 1, and on a falling transition when that bit is 0. The opposite transition leaves the flag unchanged.
- R3: A write with `wr_sel_i`=0 clears each pending flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R4: A write with `wr_sel_i`=1 loads the enable bits, and a write with `wr_sel_i`=2 loads the edge-select bits. Both read back unchanged on `enables_o` and `polarity_o`.
- R5: If an edge event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: While `ie_i`=0 the pin gives no interrupt. In level mode it is released. In edge mode it holds the inactive level (`int_o` = ~`int_pol_i`) and emits no pulse.
- R7: In level mode (`edge_mode_i`=0) with `ie_i`=1, the pin pulls low (`int_oe_o`=1, `int_o`=0) while any enabled flag is set or `other_irq_i`=1, and is released otherwise. A set flag whose enable is 0 has no effect.
- R8: In edge mode, `int_oe_o` is 1 at all times. One pulse is emitted each time the combined condition goes from inactive to active. No further pulse is emitted while the condition stays active.
- R9: The edge-mode pulse is at level `int_pol_i` and lasts PW0_CYC, PW1_CYC, PW2_CYC or PW3_CYC clock cycles for `pw_sel_i` = 00, 01, 10 or 11. The encoding 10 is the intended reset choice of the surrounding register.
- R10: When `sep_irq_i`=1 and `gpx_sel_i`=2'b10, `gpx_o` is the active-high OR of the enabled flags gated by `ie_i`, and those flags no longer affect the interrupt pin. Otherwise `gpx_o` = `gpx_src_i` and the GPIO flags take part in the pin condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gpio_i | input | 8 | General-purpose inputs (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 flags (write-1-clear), 1 enables, 2 edge selects |
| wr_data_i | input | 8 | Write data, one bit per pin |
| flags_o | output | 8 | Pending flags |
| enables_o | output | 8 | Enable bits |
| polarity_o | output | 8 | Edge-select bits (1 rising, 0 falling) |
| other_irq_i | input | 1 | Summary of other enabled interrupt sources |
| ie_i | input | 1 | Global interrupt enable |
| edge_mode_i | input | 1 | 1 pulse mode, 0 level mode |
| int_pol_i | input | 1 | Active level of the pulse in edge mode |
| pw_sel_i | input | 2 | Pulse width select |
| sep_irq_i | input | 1 | Allow GPIO interrupts on the multiplexed output |
| gpx_sel_i | input | 2 | Multiplexed output select |
| gpx_src_i | input | 1 | Signal the multiplexed output carries by default |
| int_o | output | 1 | Interrupt pin value |
| int_oe_o | output | 1 | Interrupt pin drive enable |
| gpx_o | output | 1 | Multiplexed general-purpose output |

## Verification
A wrong internal state shows up at the ports in different ways, and at different speeds.
- A corrupted pending flag or enable appears on `flags_o` or `enables_o` in the cycle after the event. It reaches `int_oe_o` in level mode in that same cycle.
- A wrong synchronizer or edge-select path shows as a flag that sets on the wrong transition, or that sets earlier or later than the third clock edge after the input changes.
- A fault in the pulse counter or in the previous-condition register shows only in edge mode. There it appears as a pulse of the wrong length, or as a second pulse while the condition is held. So the bench counts active cycles of the pin over a whole window for each width code, rather than taking one sample.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_POL  = 2'd2
  } reg_sel_e;

  localparam logic [1:0] GPX_DEDICATED = 2'b10;
endpackage

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    // [0],[1] synchronizer, [2] previous synced value
    logic [2:0] sh_q;
    logic       rise, fall;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], pin_i[i]};
    end

    assign rise     = sh_q[1] & ~sh_q[2];
    assign fall     = ~sh_q[1] & sh_q[2];
    assign hit_o[i] = pol_i[i] ? rise : fall;

    a_r2_hit_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[i] |-> (sh_q[1] != sh_q[2]));
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pol_o
);
  logic [N-1:0] flags_q, en_q, pol_q, clr;

  assign clr = (wr_en_i && wr_sel_i == SEL_FLAG) ? wr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
      pol_q   <= '0;
    end else begin
      // set dominates clear
      flags_q <= (flags_q & ~clr) | hit_i;
      if (wr_en_i && wr_sel_i == SEL_EN)  en_q  <= wr_data_i;
      if (wr_en_i && wr_sel_i == SEL_POL) pol_q <= wr_data_i;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((flags_q & $past(hit_i)) == $past(hit_i)));

  a_r3_clear_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr & ~hit_i)) |=> ((flags_q & $past(clr & ~hit_i)) == '0));

  a_r3_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_FLAG) |=>
      ((flags_q & $past(flags_q & ~wr_data_i)) == $past(flags_q & ~wr_data_i)));

  a_r4_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_EN) |=> (en_q == $past(wr_data_i)));
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int PW0_CYC = 16,
  parameter int PW1_CYC = 32,
  parameter int PW2_CYC = 64,
  parameter int PW3_CYC = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ie_i,
  input  logic       edge_mode_i,
  input  logic       pol_i,
  input  logic [1:0] pw_sel_i,
  output logic       int_o,
  output logic       int_oe_o
);
  localparam int PW_MAX01 = (PW0_CYC > PW1_CYC) ? PW0_CYC : PW1_CYC;
  localparam int PW_MAX23 = (PW2_CYC > PW3_CYC) ? PW2_CYC : PW3_CYC;
  localparam int PW_MAX   = (PW_MAX01 > PW_MAX23) ? PW_MAX01 : PW_MAX23;
  localparam int CW       = $clog2(PW_MAX + 1);

  logic [3:0][CW-1:0] width_tab;
  for (genvar k = 0; k < 4; k++) begin : g_tab
    localparam int PWK = (k == 0) ? PW0_CYC : (k == 1) ? PW1_CYC :
                         (k == 2) ? PW2_CYC : PW3_CYC;
    assign width_tab[k] = CW'(PWK);
  end

  logic          cond, cond_q, start, pulse;
  logic [CW-1:0] cnt_q;

  assign cond  = ie_i & req_i;
  assign start = cond & ~cond_q;
  assign pulse = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_q <= cond;
      if (start && edge_mode_i) cnt_q <= width_tab[pw_sel_i];
      else if (pulse)           cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    if (edge_mode_i) begin
      int_oe_o = 1'b1;
      int_o    = pulse ? pol_i : ~pol_i;
    end else begin
      int_oe_o = cond;
      int_o    = 1'b0;
    end
  end

  a_r8_edge_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i |-> int_oe_o);

  a_r8_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse && !(start && edge_mode_i)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r7_level_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && ie_i && req_i) |-> (int_oe_o && !int_o));

  a_r6_level_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !ie_i) |-> !int_oe_o);

  a_r9_width_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PW_MAX));
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int N       = 8,
  parameter int PW0_CYC = 16,
  parameter int PW1_CYC = 32,
  parameter int PW2_CYC = 64,
  parameter int PW3_CYC = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] gpio_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] enables_o,
  output logic [N-1:0] polarity_o,
  input  logic         other_irq_i,
  input  logic         ie_i,
  input  logic         edge_mode_i,
  input  logic         int_pol_i,
  input  logic [1:0]   pw_sel_i,
  input  logic         sep_irq_i,
  input  logic [1:0]   gpx_sel_i,
  input  logic         gpx_src_i,
  output logic         int_o,
  output logic         int_oe_o,
  output logic         gpx_o
);
  logic [N-1:0] hit;
  logic         gpio_req, dedicated, pin_req;

  gpio_edge_det #(.N(N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (gpio_i),
    .pol_i  (polarity_o),
    .hit_o  (hit)
  );

  gpio_irq_regs #(.N(N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .flags_o   (flags_o),
    .en_o      (enables_o),
    .pol_o     (polarity_o)
  );

  assign gpio_req  = |(flags_o & enables_o);
  assign dedicated = sep_irq_i && (gpx_sel_i == GPX_DEDICATED);
  assign pin_req   = other_irq_i | (gpio_req & ~dedicated);
  assign gpx_o     = dedicated ? (gpio_req & ie_i) : gpx_src_i;

  irq_pin_drv #(
    .PW0_CYC (PW0_CYC),
    .PW1_CYC (PW1_CYC),
    .PW2_CYC (PW2_CYC),
    .PW3_CYC (PW3_CYC)
  ) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (pin_req),
    .ie_i        (ie_i),
    .edge_mode_i (edge_mode_i),
    .pol_i       (int_pol_i),
    .pw_sel_i    (pw_sel_i),
    .int_o       (int_o),
    .int_oe_o    (int_oe_o)
  );

  a_r10_gpx_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dedicated |-> (gpx_o == gpx_src_i));

  a_r10_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dedicated && !edge_mode_i && !other_irq_i) |-> !int_oe_o);
endmodule

// File: tb/gpio_irq_top_tb.sv
module gpio_irq_top_tb;
  localparam int N = 8;
  localparam int W0 = 3, W1 = 5, W2 = 8, W3 = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] gpio = '0, wr_data = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, pw_sel = 2'b10, gpx_sel = 2'b00;
  logic other = 1'b0, ie = 1'b0, edge_mode = 1'b0, int_pol = 1'b1;
  logic sep = 1'b0, gpx_src = 1'b0;
  logic [N-1:0] flags, enables, pols;
  logic int_v, int_oe, gpx;

  always #4 clk = ~clk;

  gpio_irq_top #(.N(N), .PW0_CYC(W0), .PW1_CYC(W1), .PW2_CYC(W2), .PW3_CYC(W3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .flags_o(flags), .enables_o(enables), .polarity_o(pols),
    .other_irq_i(other), .ie_i(ie), .edge_mode_i(edge_mode), .int_pol_i(int_pol),
    .pw_sel_i(pw_sel), .sep_irq_i(sep), .gpx_sel_i(gpx_sel), .gpx_src_i(gpx_src),
    .int_o(int_v), .int_oe_o(int_oe), .gpx_o(gpx)
  );

  typedef struct {
    string       tag;
    bit          is_count;
    logic [31:0] exp_cnt;
    logic [7:0]  e_flags, e_en, e_pol;
    logic        e_int, e_oe, e_gpx;
  } item_t;

  item_t q[$];
  int vectors = 0, miscompares = 0;
  int unsigned pulse_cycles = 0;
  bit done = 1'b0;

  // active edge-mode pulse cycles seen on the pin
  always @(negedge clk)
    if (rst_n && edge_mode && int_oe && int_v == int_pol) pulse_cycles <= pulse_cycles + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      vectors++;
      if (it.is_count) begin
        if (pulse_cycles != it.exp_cnt) begin
          miscompares++;
          $display("FAIL %s: pulse count got %0d exp %0d", it.tag, pulse_cycles, it.exp_cnt);
        end
      end else if ({flags, enables, pols, int_v, int_oe, gpx} !==
                   {it.e_flags, it.e_en, it.e_pol, it.e_int, it.e_oe, it.e_gpx}) begin
        miscompares++;
        $display("FAIL %s: got fl=%h en=%h pol=%h int=%b oe=%b gpx=%b exp fl=%h en=%h pol=%h int=%b oe=%b gpx=%b",
                 it.tag, flags, enables, pols, int_v, int_oe, gpx,
                 it.e_flags, it.e_en, it.e_pol, it.e_int, it.e_oe, it.e_gpx);
      end
    end
  end

  task automatic exp_state(string tag, logic [7:0] f, logic [7:0] e, logic [7:0] p,
                           logic i, logic oe, logic g);
    item_t it;
    it.tag = tag; it.is_count = 1'b0; it.exp_cnt = 0;
    it.e_flags = f; it.e_en = e; it.e_pol = p; it.e_int = i; it.e_oe = oe; it.e_gpx = g;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic exp_count(string tag, int unsigned c);
    item_t it;
    it.tag = tag; it.is_count = 1'b1; it.exp_cnt = c;
    it.e_flags = 0; it.e_en = 0; it.e_pol = 0; it.e_int = 0; it.e_oe = 0; it.e_gpx = 0;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pins(logic [7:0] v);
    @(negedge clk); gpio = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    int unsigned base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_state("R1 reset", 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h0F);
    exp_state("R4 readback", 8'h00, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b0);

    pins(8'h01);
    exp_state("R2 rising sets, R6 ie off level", 8'h01, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b0);
    @(negedge clk); ie = 1'b1;
    @(negedge clk);
    exp_state("R7 level pull", 8'h01, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);

    pins(8'h11);
    exp_state("R2 wrong edge ignored", 8'h01, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);
    pins(8'h01);
    exp_state("R2 falling sets", 8'h11, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);

    wr(2'd0, 8'h10);
    exp_state("R3 write1 clears", 8'h01, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);
    wr(2'd0, 8'h00);
    exp_state("R3 write0 keeps", 8'h01, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);

    wr(2'd1, 8'hFE);
    exp_state("R7 disabled flag ignored", 8'h01, 8'hFE, 8'h0F, 1'b0, 1'b0, 1'b0);
    @(negedge clk); other = 1'b1;
    @(negedge clk);
    exp_state("R7 other source", 8'h01, 8'hFE, 8'h0F, 1'b0, 1'b1, 1'b0);
    @(negedge clk); other = 1'b0;
    wr(2'd1, 8'hFF);

    wr(2'd0, 8'hFF);
    pins(8'h00);
    exp_state("R3 clear all", 8'h00, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b0);

    // rising edge on pin0 sets at the same edge as a write-1 clear
    @(negedge clk); gpio = 8'h01;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    exp_state("R5 set wins", 8'h01, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);
    wr(2'd0, 8'hFF);

    // edge mode widths
    @(negedge clk); edge_mode = 1'b1; int_pol = 1'b1;
    for (int k = 0; k < 4; k++) begin
      int unsigned w;
      w = (k == 0) ? W0 : (k == 1) ? W1 : (k == 2) ? W2 : W3;
      @(negedge clk); pw_sel = 2'(k); gpio = 8'h00;
      repeat (4) @(negedge clk);
      if (k == 3) begin int_pol = 1'b0; repeat (2) @(negedge clk); end
      base = pulse_cycles;
      pins(8'h02);
      repeat (26) @(negedge clk);
      exp_count($sformatf("R9 width sel %0d", k), base + w);
      exp_state("R8 idle level driven", 8'h02, 8'hFF, 8'h0F, ~int_pol, 1'b1, 1'b0);
      if (k == 1) begin
        base = pulse_cycles;
        pins(8'h06);
        repeat (20) @(negedge clk);
        exp_count("R8 no pulse while held", base);
      end
      wr(2'd0, 8'hFF);
    end

    // global enable off in edge mode
    @(negedge clk); ie = 1'b0; gpio = 8'h00; int_pol = 1'b1;
    repeat (6) @(negedge clk);
    base = pulse_cycles;
    pins(8'h04);
    repeat (20) @(negedge clk);
    exp_count("R6 edge mode no pulse", base);
    exp_state("R6 edge inactive level", 8'h04, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);
    wr(2'd0, 8'hFF);

    // dedicated GPIO output
    @(negedge clk); edge_mode = 1'b0; ie = 1'b1; sep = 1'b1; gpx_sel = 2'b10; gpio = 8'h00;
    repeat (5) @(negedge clk);
    pins(8'h08);
    exp_state("R10 dedicated gpx", 8'h08, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b1);
    @(negedge clk); other = 1'b1;
    @(negedge clk);
    exp_state("R10 other stays on pin", 8'h08, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b1);
    @(negedge clk); other = 1'b0; gpx_sel = 2'b01; gpx_src = 1'b1;
    @(negedge clk);
    exp_state("R10 default route", 8'h08, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b1);
    @(negedge clk); gpx_src = 1'b0;
    @(negedge clk);
    exp_state("R10 default route low", 8'h08, 8'hFF, 8'h0F, 1'b0, 1'b1, 1'b0);

    finish_run();
  end
endmodule